// File: doc/BRIEF.md
# Per-Pin Drive Waveform Formatter

This block shapes the drive waveform of one tester pin, one test cycle at a time. Each cycle is split into `SLOTS` equal time slots, counted by an internal slot timer. Two timing markers divide the cycle:

- a leading marker that asserts from a programmed leading slot onward;
- a trailing marker that asserts from a programmed trailing slot onward.

The slots where the leading marker is asserted and the trailing marker is not form the pulse window.

Five drive formats combine the cycle's data bit with these markers: non-return-to-zero, return-to-zero, return-to-one, return-to-complement and return-to-tristate. A one-hot selector picks the format. Each marker has force-low and force-high controls. These let calibration software hold the pin at a constant level, or pass a single edge through.

The data bit, format, slot positions and force bits are taken in only at the cycle boundary, so a cycle never mixes two settings. A separate phase comparator captures the observed pin level when a reference strobe arrives. That tells software whether the observed edge came before the reference.

Top module: `wf_pin_formatter`

## Requirements
- R1: The format selector is one-hot: bit 0 non-return-to-zero, bit 1 return-to-zero, bit 2 return-to-one, bit 3 return-to-complement, bit 4 return-to-tristate. Any value with zero bits or several bits set drives `pin_drive` 0 and `pin_oe` 0.
- R2: Non-return-to-zero behaves as follows:
  - before the leading slot, `pin_drive` keeps the previous cycle's data bit;
  - from the leading slot onward, `pin_drive` carries the new data bit;
  - `pin_oe` is 1 and the trailing marker has no effect.
- R3: In return-to-zero, a data bit of 1 gives `pin_drive` 1 exactly in the pulse window and 0 elsewhere. A data bit of 0 keeps `pin_drive` 0. `pin_oe` is 1.
- R4: In return-to-one, a data bit of 0 gives `pin_drive` 0 exactly in the pulse window and 1 elsewhere. A data bit of 1 keeps `pin_drive` 1. `pin_oe` is 1.
- R5: In return-to-complement, `pin_drive` equals the data bit inside the pulse window and its inverse outside it. `pin_oe` is 1.
- R6: In return-to-tristate, `pin_drive` equals the data bit and `pin_oe` is 1 only inside the pulse window.
- R7: When the trailing slot is not later than the leading slot, the pulse window is empty and the pin stays at the format's resting level for the whole cycle. A slot position of `SLOTS` or more is never reached.
- R8: A marker's force-low bit holds that marker deasserted for the whole cycle. Its force-high bit holds it asserted for the whole cycle. Force-low wins when both are set.
- R9: Data, format, slot positions and force bits are loaded only at the cycle boundary, that is, the clock edge that leaves the last slot. A change during a cycle affects the pin only from the next cycle.
- R10: `cycle_mark` is 1 only in slot 0. The slot count runs 0 to `SLOTS`-1 and wraps.
- R11: A clock edge with `ref_strobe` high loads `edge_early` with `pin_obs`. Without a strobe, `edge_early` holds its value.
- R12: While `rst_n` is low, the outputs are as follows:
  - `pin_drive`, `pin_oe` and `edge_early` are 0;
  - `cycle_mark` is 1;
  - the first cycle after reset runs with all settings cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_data | input | 1 | Data bit for the next cycle |
| fmt_sel | input | 5 | One-hot drive format for the next cycle |
| lead_pos | input | POS_W | Leading marker slot position |
| trail_pos | input | POS_W | Trailing marker slot position |
| lead_force_lo | input | 1 | Hold leading marker deasserted |
| lead_force_hi | input | 1 | Hold leading marker asserted |
| trail_force_lo | input | 1 | Hold trailing marker deasserted |
| trail_force_hi | input | 1 | Hold trailing marker asserted |
| pin_obs | input | 1 | Observed pin level for phase compare |
| ref_strobe | input | 1 | Reference strobe for phase compare |
| pin_drive | output | 1 | Driver data level |
| pin_oe | output | 1 | Driver enable |
| cycle_mark | output | 1 | High in slot 0 of each cycle |
| edge_early | output | 1 | Captured phase-compare result |

## Verification
- A slot timer that is off by one shifts every leading and trailing edge by one slot. It also moves `cycle_mark` out of slot 0. Both show up in the first cycle checked after reset.
- A setting loaded at the wrong moment shows in the same cycle the stimulus changes. Either the pin follows the new format part-way through a cycle, or the pin drives the wrong previous level before a non-return-to-zero edge.
- A swapped format term, or a wrong force priority, shows as one or more wrong slots in the sweep cycle that uses that format or force.

// File: rtl/wf_fmt_pkg.sv
package wf_fmt_pkg;
   localparam int FMT_W   = 5;
   localparam int FMT_NRZ = 0;
   localparam int FMT_RZ  = 1;
   localparam int FMT_RO  = 2;
   localparam int FMT_RC  = 3;
   localparam int FMT_RT  = 4;

   typedef struct packed {
      logic hi;
      logic lo;
   } force_t;
endpackage

// File: rtl/wf_cycle_timer.sv
module wf_cycle_timer #(
   parameter int SLOTS = 20,
   parameter int POS_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [POS_W-1:0] slot,
   output logic             wrap
);
   localparam logic [POS_W-1:0] LAST = POS_W'(SLOTS - 1);

   assign wrap = (slot == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot <= '0;
      else if (wrap)  slot <= '0;
      else            slot <= slot + POS_W'(1);
   end
endmodule

// File: rtl/wf_marker.sv
module wf_marker
   import wf_fmt_pkg::*;
#(
   parameter int POS_W = 5
) (
   input  logic [POS_W-1:0] slot,
   input  logic [POS_W-1:0] pos,
   input  force_t           frc,
   output logic             mark
);
   always_comb begin
      if (frc.lo)      mark = 1'b0;
      else if (frc.hi) mark = 1'b1;
      else             mark = (slot >= pos);
   end
endmodule

// File: rtl/wf_shaper.sv
module wf_shaper
   import wf_fmt_pkg::*;
(
   input  logic [FMT_W-1:0] fmt,
   input  logic             data,
   input  logic             prev,
   input  logic             lead_mark,
   input  logic             trail_mark,
   output logic             drive,
   output logic             oe
);
   logic             win;
   logic             legal;
   logic [FMT_W-1:0] term_d;
   logic [FMT_W-1:0] term_oe;

   assign win   = lead_mark & ~trail_mark;
   assign legal = $onehot(fmt);

   for (genvar g = 0; g < FMT_W; g++) begin : g_fmt
      if (g == FMT_NRZ) begin : g_nrz
         assign term_d[g]  = lead_mark ? data : prev;
         assign term_oe[g] = 1'b1;
      end else if (g == FMT_RZ) begin : g_rz
         assign term_d[g]  = data & win;
         assign term_oe[g] = 1'b1;
      end else if (g == FMT_RO) begin : g_ro
         assign term_d[g]  = data | ~win;
         assign term_oe[g] = 1'b1;
      end else if (g == FMT_RC) begin : g_rc
         assign term_d[g]  = win ? data : ~data;
         assign term_oe[g] = 1'b1;
      end else begin : g_rt
         assign term_d[g]  = data;
         assign term_oe[g] = win;
      end
   end

   assign drive = legal & (|(term_d & fmt));
   assign oe    = legal & (|(term_oe & fmt));
endmodule

// File: rtl/wf_pin_formatter.sv
module wf_pin_formatter
   import wf_fmt_pkg::*;
#(
   parameter  int SLOTS = 20,
   localparam int POS_W = (SLOTS > 2) ? $clog2(SLOTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drv_data,
   input  logic [FMT_W-1:0] fmt_sel,
   input  logic [POS_W-1:0] lead_pos,
   input  logic [POS_W-1:0] trail_pos,
   input  logic             lead_force_lo,
   input  logic             lead_force_hi,
   input  logic             trail_force_lo,
   input  logic             trail_force_hi,
   input  logic             pin_obs,
   input  logic             ref_strobe,
   output logic             pin_drive,
   output logic             pin_oe,
   output logic             cycle_mark,
   output logic             edge_early
);
   if (SLOTS < 2 || SLOTS > 256) begin : g_bad_slots
      $error("wf_pin_formatter: SLOTS must lie in 2..256");
   end

   logic [POS_W-1:0] slot_q;
   logic             wrap;
   logic             data_act, prev_act;
   logic [FMT_W-1:0] fmt_act;
   logic [POS_W-1:0] lead_act, trail_act;
   force_t           lfrc_act, tfrc_act;
   logic             lead_mark, trail_mark;

   wf_cycle_timer #(.SLOTS(SLOTS), .POS_W(POS_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot_q),
      .wrap  (wrap)
   );

   // settings are shadowed and applied only at the cycle boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_act  <= 1'b0;
         prev_act  <= 1'b0;
         fmt_act   <= '0;
         lead_act  <= '0;
         trail_act <= '0;
         lfrc_act  <= '0;
         tfrc_act  <= '0;
      end else if (wrap) begin
         prev_act  <= data_act;
         data_act  <= drv_data;
         fmt_act   <= fmt_sel;
         lead_act  <= lead_pos;
         trail_act <= trail_pos;
         lfrc_act  <= '{hi: lead_force_hi,  lo: lead_force_lo};
         tfrc_act  <= '{hi: trail_force_hi, lo: trail_force_lo};
      end
   end

   wf_marker #(.POS_W(POS_W)) u_lead (
      .slot (slot_q),
      .pos  (lead_act),
      .frc  (lfrc_act),
      .mark (lead_mark)
   );

   wf_marker #(.POS_W(POS_W)) u_trail (
      .slot (slot_q),
      .pos  (trail_act),
      .frc  (tfrc_act),
      .mark (trail_mark)
   );

   wf_shaper u_shape (
      .fmt        (fmt_act),
      .data       (data_act),
      .prev       (prev_act),
      .lead_mark  (lead_mark),
      .trail_mark (trail_mark),
      .drive      (pin_drive),
      .oe         (pin_oe)
   );

   assign cycle_mark = (slot_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          edge_early <= 1'b0;
      else if (ref_strobe) edge_early <= pin_obs;
   end
endmodule

// File: rtl/wf_pin_formatter_chk.sv
module wf_pin_formatter_chk
   import wf_fmt_pkg::*;
#(
   parameter int SLOTS = 20,
   parameter int POS_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [POS_W-1:0] slot_q,
   input logic [FMT_W-1:0] fmt_act,
   input logic             data_act,
   input logic             pin_drive,
   input logic             pin_oe,
   input logic             cycle_mark,
   input logic             pin_obs,
   input logic             ref_strobe,
   input logic             edge_early
);
   AST_ILLEGAL_FMT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$onehot(fmt_act) |-> (!pin_oe && !pin_drive)); // R1
   AST_NRZ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_act == FMT_W'(1 << FMT_NRZ)) |-> pin_oe); // R2
   AST_RZ_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((fmt_act == FMT_W'(1 << FMT_RZ)) && !data_act) |-> !pin_drive); // R3
   AST_RO_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((fmt_act == FMT_W'(1 << FMT_RO)) && data_act) |-> pin_drive); // R4
   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q != '0) |-> ($stable(fmt_act) && $stable(data_act))); // R9
   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(slot_q) < SLOTS)); // R10
   AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_mark |=> !cycle_mark); // R10
   AST_CMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_strobe |=> (edge_early == $past(pin_obs))); // R11
   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_strobe |=> $stable(edge_early)); // R11
endmodule

bind wf_pin_formatter wf_pin_formatter_chk #(.SLOTS(SLOTS), .POS_W(POS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slot_q     (slot_q),
   .fmt_act    (fmt_act),
   .data_act   (data_act),
   .pin_drive  (pin_drive),
   .pin_oe     (pin_oe),
   .cycle_mark (cycle_mark),
   .pin_obs    (pin_obs),
   .ref_strobe (ref_strobe),
   .edge_early (edge_early)
);

// File: tb/sim_wf_pin_formatter.sv
module sim_wf_pin_formatter;
   localparam int CLK_PERIOD = 10;
   localparam int SLOTS      = 20;
   localparam int POS_W      = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic drv_data = 1'b0;
   logic [4:0] fmt_sel = '0;
   logic [POS_W-1:0] lead_pos = '0, trail_pos = '0;
   logic lead_force_lo = 1'b0, lead_force_hi = 1'b0;
   logic trail_force_lo = 1'b0, trail_force_hi = 1'b0;
   logic pin_obs = 1'b0, ref_strobe = 1'b0;
   logic pin_drive, pin_oe, cycle_mark, edge_early;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // model of the cycle under check
   logic       m_d, m_prev, m_last;
   logic [4:0] m_fmt;
   int         m_lead, m_trail;
   logic [1:0] m_lf, m_tf;   // {hi, lo}

   always #(CLK_PERIOD/2) clk = ~clk;

   wf_pin_formatter #(.SLOTS(SLOTS)) u0 (
      .clk(clk), .rst_n(rst_n), .drv_data(drv_data), .fmt_sel(fmt_sel),
      .lead_pos(lead_pos), .trail_pos(trail_pos),
      .lead_force_lo(lead_force_lo), .lead_force_hi(lead_force_hi),
      .trail_force_lo(trail_force_lo), .trail_force_hi(trail_force_hi),
      .pin_obs(pin_obs), .ref_strobe(ref_strobe),
      .pin_drive(pin_drive), .pin_oe(pin_oe),
      .cycle_mark(cycle_mark), .edge_early(edge_early)
   );

   function automatic logic [1:0] model(int k);
      logic lm, tm, w, dr, oe;
      lm = m_lf[0] ? 1'b0 : (m_lf[1] ? 1'b1 : (k >= m_lead));
      tm = m_tf[0] ? 1'b0 : (m_tf[1] ? 1'b1 : (k >= m_trail));
      w  = lm & ~tm;
      oe = 1'b1;
      case (m_fmt)
         5'b00001: dr = lm ? m_d : m_prev;
         5'b00010: dr = m_d & w;
         5'b00100: dr = m_d | ~w;
         5'b01000: dr = w ? m_d : ~m_d;
         5'b10000: begin dr = m_d; oe = w; end
         default:  begin dr = 1'b0; oe = 1'b0; end
      endcase
      return {dr, oe};
   endfunction

   task automatic check(string tag, string what, logic [1:0] got, logic [1:0] exp);
      n_total++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
      end
   endtask

   task automatic check_slot(int k, string tag);
      check(tag, $sformatf("slot %0d {drive,oe}", k), {pin_drive, pin_oe}, model(k));
      check("R10", $sformatf("slot %0d cycle_mark", k), {1'b0, cycle_mark}, {1'b0, k == 0});
   endtask

   task automatic set_in(logic d, logic [4:0] f, int l, int t, logic [1:0] lf, logic [1:0] tf);
      drv_data = d; fmt_sel = f;
      lead_pos = POS_W'(l); trail_pos = POS_W'(t);
      lead_force_hi = lf[1];  lead_force_lo = lf[0];
      trail_force_hi = tf[1]; trail_force_lo = tf[0];
   endtask

   task automatic set_model(logic d, logic [4:0] f, int l, int t, logic [1:0] lf, logic [1:0] tf);
      m_prev = m_last; m_d = d; m_fmt = f; m_lead = l; m_trail = t; m_lf = lf; m_tf = tf;
   endtask

   task automatic start_cycle();
      @(negedge clk);
      while (!cycle_mark) @(negedge clk);
   endtask

   task automatic run_test(logic d, logic [4:0] f, int l, int t, logic [1:0] lf, logic [1:0] tf, string tag);
      set_in(d, f, l, t, lf, tf);
      start_cycle();
      set_model(d, f, l, t, lf, tf);
      for (int k = 0; k < SLOTS; k++) begin
         check_slot(k, tag);
         @(negedge clk);
      end
      m_last = d;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++; n_total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      int pos_list[4];
      string ftag[5];
      pos_list = '{0, 4, 9, 19};
      ftag = '{"R2", "R3", "R4", "R5", "R6"};
      m_last = 1'b0;

      // R12: reset state
      repeat (3) @(negedge clk);
      check("R12", "reset {drive,oe}", {pin_drive, pin_oe}, 2'b00);
      check("R12", "reset edge_early", {1'b0, edge_early}, 2'b00);
      check("R12", "reset cycle_mark", {1'b0, cycle_mark}, 2'b01);
      rst_n = 1'b1;

      // R12: first cycle after reset runs with cleared settings (driver off)
      set_model(1'b0, 5'b0, 0, 0, 2'b00, 2'b00);
      check_slot(0, "R12");

      // R2..R7: sweep of formats, data and slot positions
      for (int fi = 0; fi < 5; fi++)
         for (int d = 0; d < 2; d++)
            for (int li = 0; li < 4; li++)
               for (int ti = 0; ti < 4; ti++)
                  run_test(d[0], 5'(1 << fi), pos_list[li], pos_list[ti], 2'b00, 2'b00,
                           (pos_list[ti] <= pos_list[li] && fi != 0) ? "R7" : ftag[fi]);

      // R7: positions never reached
      run_test(1'b1, 5'b00010, 31, 25, 2'b00, 2'b00, "R7");
      run_test(1'b1, 5'b00001, 31, 3, 2'b00, 2'b00, "R7");

      // R1: non-one-hot formats
      run_test(1'b1, 5'b00000, 2, 8, 2'b00, 2'b00, "R1");
      run_test(1'b1, 5'b00011, 2, 8, 2'b00, 2'b00, "R1");
      run_test(1'b0, 5'b11111, 2, 8, 2'b00, 2'b00, "R1");

      // R8: force controls
      for (int d = 0; d < 2; d++) begin
         run_test(d[0], 5'b00010, 4, 9, 2'b10, 2'b00, "R8");
         run_test(d[0], 5'b00010, 4, 9, 2'b01, 2'b00, "R8");
         run_test(d[0], 5'b00100, 4, 9, 2'b00, 2'b01, "R8");
         run_test(d[0], 5'b00100, 4, 9, 2'b00, 2'b10, "R8");
         run_test(d[0], 5'b01000, 4, 9, 2'b11, 2'b00, "R8");
         run_test(d[0], 5'b10000, 4, 9, 2'b10, 2'b01, "R8");
         run_test(d[0], 5'b00001, 4, 9, 2'b01, 2'b10, "R8");
      end

      // R9: mid-cycle change waits for the boundary
      set_in(1'b1, 5'b00010, 2, 6, 2'b00, 2'b00);
      start_cycle();
      set_model(1'b1, 5'b00010, 2, 6, 2'b00, 2'b00);
      for (int k = 0; k < SLOTS; k++) begin
         check_slot(k, "R9");
         if (k == 4) set_in(1'b0, 5'b00100, 10, 15, 2'b00, 2'b00);
         @(negedge clk);
      end
      m_last = 1'b1;
      set_model(1'b0, 5'b00100, 10, 15, 2'b00, 2'b00);
      for (int k = 0; k < SLOTS; k++) begin
         check_slot(k, "R9");
         @(negedge clk);
      end
      m_last = 1'b0;

      // R11: phase compare capture and hold
      pin_obs = 1'b1; ref_strobe = 1'b1;
      @(negedge clk);
      ref_strobe = 1'b0;
      check("R11", "capture 1", {1'b0, edge_early}, 2'b01);
      pin_obs = 1'b0;
      repeat (2) @(negedge clk);
      check("R11", "hold without strobe", {1'b0, edge_early}, 2'b01);
      ref_strobe = 1'b1;
      @(negedge clk);
      ref_strobe = 1'b0;
      check("R11", "capture 0", {1'b0, edge_early}, 2'b00);
      pin_obs = 1'b1;
      repeat (2) @(negedge clk);
      check("R11", "hold low", {1'b0, edge_early}, 2'b00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule